// File: doc/BRIEF.md
# Register-to-register transfer sequencer

This block is the control side of a shared register bus. Each job it runs moves one word: it reads a register in one module and writes that value into a register of another module. The bus it drives carries an address, a read strobe, a write strobe and the outgoing data word. Every module on the bus returns a ready flag for reads and a busy flag that holds off writes. The read data comes back on one shared input word.

A job starts in one of two ways. Software-side control logic can give a source address, a destination address and a start pulse on the command port. A module can also ask for service by raising its service-request line. For a module request, the source and destination come from a fixed route that is set by parameters. The sequencer presents the read address and waits for the addressed module's ready flag. It then strobes the read for one cycle and latches the returned word. Next it presents the destination address together with the latched word, waits until the destination module's busy flag is low, and strobes the write for one cycle. The end of the job is marked with a one-cycle completion pulse. If the ready flag never arrives, a watchdog counter abandons the job and raises a one-cycle error pulse.

Top module: `regxfer_master`

## Requirements
- R1: A job is exactly one read cycle (bus_rd high for one cycle) followed by exactly one write cycle (bus_wr high for one cycle). bus_rd and bus_wr are never high together, and the destination register receives the word read from the source.
- R2: cmd_start is sampled in the idle state, and it takes precedence over any pending service request. Take the clock edge that samples cmd_start as edge 1. With ready already high and busy low, cmd_done is high in the cycle after edge 7. The first read address is cmd_src.
- R3: bus_rd rises only after the module selected by the address's upper MOD_W bits has shown rdy high in the previous cycle. bus_din is latched in the cycle in which bus_rd is high.
- R4: Among pending rd_int lines the lowest index is served first. For module i the source address is {i, REQ_REG} and the destination is {(i+DST_OFFSET) mod N_MOD, DST_REG}, with the module number in the upper MOD_W address bits.
- R5: bus_wr rises only after the destination module's busy was low in the previous cycle. While busy stays high, no write is issued.
- R6: bus_dout carries the latched source word and does not change between the write set-up and the write strobe.
- R7: cmd_done is a pulse of one cycle, and there is one pulse for each completed job.
- R8: If rdy stays low for WAIT_LIMIT cycles of the wait state, the job is dropped. xfer_err pulses for one cycle in the cycle after edge WAIT_LIMIT+2, counting the start edge as edge 1. No write and no cmd_done occur for that job, and the next job runs normally.
- R9: A cmd_start that arrives while a job is in progress is ignored. It causes no extra read, no extra write and no extra cmd_done.
- R10: After reset, bus_rd, bus_wr, cmd_done and xfer_err are low and bus_addr is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Starts a commanded job when idle |
| cmd_src | input | ADDR_W | Source register address for a commanded job |
| cmd_dst | input | ADDR_W | Destination register address for a commanded job |
| cmd_done | output | 1 | One-cycle completion pulse |
| xfer_err | output | 1 | One-cycle pulse when a read times out |
| rd_int | input | N_MOD | Per-module service requests |
| rdy | input | N_MOD | Per-module read-ready flags |
| busy | input | N_MOD | Per-module write hold-off flags |
| bus_din | input | DATA_W | Shared read data returned by the modules |
| bus_addr | output | ADDR_W | Bus address: module number in upper bits, register below |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_dout | output | DATA_W | Write data |

## Verification
Some rules are checked by assertions on every clock cycle. The read and write strobes are mutually exclusive. A read strobe is always preceded by the addressed module's ready flag, and a write strobe by a low busy flag on the destination. Both strobes last one cycle, the write data is stable during the strobe, the completion pulse is one cycle wide, and the wait counter stays within its limit. Other behaviour can only be shown by the bench's scenarios. These are the exact cycle counts of a job and of a timeout, which module wins when several requests are pending, and the parameter-derived route addresses. The scenarios also show that the destination register really ends up holding the source value, and that a start pulse during a busy job leaves every register untouched.

// File: rtl/regxfer_pkg.sv
package regxfer_pkg;

   typedef enum logic [2:0] {
      XS_IDLE      = 3'd0,
      XS_RD_ADDR   = 3'd1,
      XS_RD_WAIT   = 3'd2,
      XS_RD_CAP    = 3'd3,
      XS_WR_SETUP  = 3'd4,
      XS_WR_WAIT   = 3'd5,
      XS_WR_STROBE = 3'd6,
      XS_DONE      = 3'd7
   } xfer_state_e;

   function automatic bit is_pow2(int unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/regxfer_req_pick.sv
module regxfer_req_pick #(
   parameter int N_MOD      = 4,
   parameter int MOD_W      = 2,
   parameter int REG_W      = 3,
   parameter int REQ_REG    = 0,
   parameter int DST_REG    = 1,
   parameter int DST_OFFSET = 1,
   localparam int ADDR_W    = MOD_W + REG_W
) (
   input  logic [N_MOD-1:0]  req,
   output logic              pick_valid,
   output logic [ADDR_W-1:0] pick_src,
   output logic [ADDR_W-1:0] pick_dst
);

   logic [ADDR_W-1:0] src_tab [N_MOD];
   logic [ADDR_W-1:0] dst_tab [N_MOD];
   logic [MOD_W-1:0]  pick_idx;

   // Fixed per-module routes, computed from the parameters
   for (genvar gi = 0; gi < N_MOD; gi++) begin : g_route
      localparam int DST_MOD = (gi + DST_OFFSET) % N_MOD;
      assign src_tab[gi] = {MOD_W'(gi), REG_W'(REQ_REG)};
      assign dst_tab[gi] = {MOD_W'(DST_MOD), REG_W'(DST_REG)};
   end

   // Lowest index wins: scan from the top so that the last hit is the lowest
   always_comb begin
      pick_valid = 1'b0;
      pick_idx   = '0;
      for (int i = N_MOD - 1; i >= 0; i--) begin
         if (req[i]) begin
            pick_valid = 1'b1;
            pick_idx   = MOD_W'(i);
         end
      end
   end

   assign pick_src = src_tab[pick_idx];
   assign pick_dst = dst_tab[pick_idx];

endmodule

// File: rtl/regxfer_wait_timer.sv
module regxfer_wait_timer #(
   parameter int WAIT_LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);

   if (WAIT_LIMIT == 0) begin : g_no_limit
      // Watchdog disabled: the sequencer waits for ready indefinitely
      assign expired = 1'b0;
   end else begin : g_limit
      localparam int CNT_W = $clog2(WAIT_LIMIT + 1);
      logic [CNT_W-1:0] cnt_q;

      assign expired = run && (cnt_q == CNT_W'(WAIT_LIMIT - 1));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (!run) begin
            cnt_q <= '0;
         end else if (!expired) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end

      AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
         run |-> (cnt_q < CNT_W'(WAIT_LIMIT))) else $error("wait counter overran"); // R8
   end

endmodule

// File: rtl/regxfer_seq.sv
module regxfer_seq
   import regxfer_pkg::*;
#(
   parameter int N_MOD  = 4,
   parameter int MOD_W  = 2,
   parameter int ADDR_W = 5,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_start,
   input  logic [ADDR_W-1:0] cmd_src,
   input  logic [ADDR_W-1:0] cmd_dst,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_src,
   input  logic [ADDR_W-1:0] req_dst,
   input  logic [N_MOD-1:0]  rdy,
   input  logic [N_MOD-1:0]  busy,
   input  logic [DATA_W-1:0] bus_din,
   input  logic              expired,
   output logic              wait_run,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_rd,
   output logic              bus_wr,
   output logic [DATA_W-1:0] bus_dout,
   output logic              xfer_done,
   output logic              xfer_err
);

   xfer_state_e       state_q, state_d;
   logic [ADDR_W-1:0] src_q, dst_q;
   logic [DATA_W-1:0] data_q;
   logic              err_q;
   logic              rdy_sel, busy_sel;
   logic              load_cmd, load_req, abort;

   assign rdy_sel  = rdy[src_q[ADDR_W-1 -: MOD_W]];
   assign busy_sel = busy[dst_q[ADDR_W-1 -: MOD_W]];

   // Command port outranks module requests; both only looked at when idle
   assign load_cmd = (state_q == XS_IDLE) && cmd_start;
   assign load_req = (state_q == XS_IDLE) && !cmd_start && req_valid;
   assign abort    = (state_q == XS_RD_WAIT) && !rdy_sel && expired;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         XS_IDLE:      if (load_cmd || load_req) state_d = XS_RD_ADDR;
         XS_RD_ADDR:   state_d = XS_RD_WAIT;
         XS_RD_WAIT: begin
            if (rdy_sel)    state_d = XS_RD_CAP;
            else if (abort) state_d = XS_IDLE;
         end
         XS_RD_CAP:    state_d = XS_WR_SETUP;
         XS_WR_SETUP:  state_d = XS_WR_WAIT;
         XS_WR_WAIT:   if (!busy_sel) state_d = XS_WR_STROBE;
         XS_WR_STROBE: state_d = XS_DONE;
         XS_DONE:      state_d = XS_IDLE;
         default:      state_d = XS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= XS_IDLE;
         src_q   <= '0;
         dst_q   <= '0;
         data_q  <= '0;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         err_q   <= abort;
         if (load_cmd) begin
            src_q <= cmd_src;
            dst_q <= cmd_dst;
         end else if (load_req) begin
            src_q <= req_src;
            dst_q <= req_dst;
         end
         if (state_q == XS_RD_CAP) data_q <= bus_din;
      end
   end

   always_comb begin
      unique case (state_q)
         XS_RD_ADDR, XS_RD_WAIT, XS_RD_CAP:              bus_addr = src_q;
         XS_WR_SETUP, XS_WR_WAIT, XS_WR_STROBE, XS_DONE: bus_addr = dst_q;
         default:                                        bus_addr = '0;
      endcase
   end

   assign bus_rd    = (state_q == XS_RD_CAP);
   assign bus_wr    = (state_q == XS_WR_STROBE);
   assign bus_dout  = data_q;
   assign xfer_done = (state_q == XS_DONE);
   assign xfer_err  = err_q;
   assign wait_run  = (state_q == XS_RD_WAIT);

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && bus_wr)) else $error("read and write together"); // R1
   AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |=> !bus_rd) else $error("read strobe too long"); // R1
   AST_RD_AFTER_RDY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_rd) |-> $past(rdy_sel)) else $error("read without ready"); // R3
   AST_WR_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_wr) |-> !$past(busy_sel)) else $error("write while busy"); // R5
   AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr |=> !bus_wr) else $error("write strobe too long"); // R5
   AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr |-> $stable(bus_dout)) else $error("write data moved"); // R6
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |=> !xfer_done) else $error("done wider than a cycle"); // R7
   AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_err |-> (!xfer_done && !bus_wr && !bus_rd)) else $error("abort with activity"); // R8

endmodule

// File: rtl/regxfer_master.sv
module regxfer_master #(
   parameter int N_MOD      = 4,
   parameter int REG_W      = 3,
   parameter int DATA_W     = 16,
   parameter int WAIT_LIMIT = 16,
   parameter int REQ_REG    = 0,
   parameter int DST_REG    = 1,
   parameter int DST_OFFSET = 1,
   localparam int MOD_W     = (N_MOD < 2) ? 1 : $clog2(N_MOD),
   localparam int ADDR_W    = MOD_W + REG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_start,
   input  logic [ADDR_W-1:0] cmd_src,
   input  logic [ADDR_W-1:0] cmd_dst,
   output logic              cmd_done,
   output logic              xfer_err,
   input  logic [N_MOD-1:0]  rd_int,
   input  logic [N_MOD-1:0]  rdy,
   input  logic [N_MOD-1:0]  busy,
   input  logic [DATA_W-1:0] bus_din,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_rd,
   output logic              bus_wr,
   output logic [DATA_W-1:0] bus_dout
);

   // Elaboration-time parameter checks
   if (N_MOD < 2 || !regxfer_pkg::is_pow2(N_MOD)) begin : g_bad_nmod
      $error("N_MOD must be a power of two and at least 2");
   end
   if (REG_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("REG_W and DATA_W must be positive");
   end
   if (REQ_REG >= (1 << REG_W) || DST_REG >= (1 << REG_W)) begin : g_bad_reg
      $error("route register index exceeds REG_W");
   end
   if (WAIT_LIMIT < 0) begin : g_bad_limit
      $error("WAIT_LIMIT must not be negative");
   end

   logic              req_valid;
   logic [ADDR_W-1:0] req_src, req_dst;
   logic              wait_run, expired;

   regxfer_req_pick #(
      .N_MOD(N_MOD), .MOD_W(MOD_W), .REG_W(REG_W),
      .REQ_REG(REQ_REG), .DST_REG(DST_REG), .DST_OFFSET(DST_OFFSET)
   ) u_pick (
      .req        (rd_int),
      .pick_valid (req_valid),
      .pick_src   (req_src),
      .pick_dst   (req_dst)
   );

   regxfer_wait_timer #(.WAIT_LIMIT(WAIT_LIMIT)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (wait_run),
      .expired (expired)
   );

   regxfer_seq #(
      .N_MOD(N_MOD), .MOD_W(MOD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_start (cmd_start),
      .cmd_src   (cmd_src),
      .cmd_dst   (cmd_dst),
      .req_valid (req_valid),
      .req_src   (req_src),
      .req_dst   (req_dst),
      .rdy       (rdy),
      .busy      (busy),
      .bus_din   (bus_din),
      .expired   (expired),
      .wait_run  (wait_run),
      .bus_addr  (bus_addr),
      .bus_rd    (bus_rd),
      .bus_wr    (bus_wr),
      .bus_dout  (bus_dout),
      .xfer_done (cmd_done),
      .xfer_err  (xfer_err)
   );

endmodule

// File: tb/regxfer_master_tb.sv
`timescale 1ns/1ps
module regxfer_master_tb;

   localparam int N_MOD  = 4;
   localparam int REG_W  = 3;
   localparam int DATA_W = 16;
   localparam int LIMIT  = 6;
   localparam int MOD_W  = 2;
   localparam int ADDR_W = MOD_W + REG_W;
   localparam int NREG   = 1 << ADDR_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cmd_start = 1'b0;
   logic [ADDR_W-1:0] cmd_src = '0, cmd_dst = '0;
   logic              cmd_done, xfer_err;
   logic [N_MOD-1:0]  rd_int = '0, rdy, busy_force = '0, rdy_en = '1;
   logic [DATA_W-1:0] bus_din, bus_dout;
   logic [ADDR_W-1:0] bus_addr;
   logic              bus_rd, bus_wr;

   logic [DATA_W-1:0] mem [NREG];

   int vectors = 0, fails = 0;
   int rd_cyc = 0, wr_cyc = 0, done_cnt = 0, err_cnt = 0, viol_rd = 0, viol_wr = 0;
   bit seen_rd = 0;
   logic [ADDR_W-1:0] first_rd = '0;
   logic [DATA_W-1:0] last_wr_data = '0;

   always #2 clk = ~clk;

   regxfer_master #(
      .N_MOD(N_MOD), .REG_W(REG_W), .DATA_W(DATA_W), .WAIT_LIMIT(LIMIT),
      .REQ_REG(0), .DST_REG(1), .DST_OFFSET(1)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_src(cmd_src),
      .cmd_dst(cmd_dst), .cmd_done(cmd_done), .xfer_err(xfer_err),
      .rd_int(rd_int), .rdy(rdy), .busy(busy_force), .bus_din(bus_din),
      .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_dout(bus_dout)
   );

   // Slave models: register file, ready per addressed module
   assign bus_din = mem[bus_addr];
   always_comb begin
      for (int m = 0; m < N_MOD; m++)
         rdy[m] = rdy_en[m] && (bus_addr[ADDR_W-1 -: MOD_W] == MOD_W'(m));
   end
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) mem[i] <= DATA_W'(16'h1000 + i * 16'h0111);
      end else if (bus_wr) begin
         mem[bus_addr] <= bus_dout;
      end
   end

   // Monitor, sampled away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (bus_rd) begin
            rd_cyc++;
            if (!rdy[bus_addr[ADDR_W-1 -: MOD_W]]) viol_rd++;
            if (!seen_rd) begin seen_rd = 1; first_rd = bus_addr; end
         end
         if (bus_wr) begin
            wr_cyc++;
            if (busy_force[bus_addr[ADDR_W-1 -: MOD_W]]) viol_wr++;
            last_wr_data = bus_dout;
         end
         if (cmd_done) done_cnt++;
         if (xfer_err) err_cnt++;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic clear_mon();
      rd_cyc = 0; wr_cyc = 0; done_cnt = 0; err_cnt = 0;
      viol_rd = 0; viol_wr = 0; seen_rd = 0;
   endtask

   // Leaves at the negedge just after the sampling edge
   task automatic pulse_start(input int src, input int dst);
      @(negedge clk);
      cmd_src = ADDR_W'(src); cmd_dst = ADDR_W'(dst); cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
   endtask

   task automatic wait_end(output int extra);
      extra = 0;
      while (!cmd_done && !xfer_err && extra < 300) begin
         @(negedge clk);
         extra++;
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      check(!bus_rd && !bus_wr, "R10", "strobes after reset", {bus_rd, bus_wr}, 0);
      check(!cmd_done && !xfer_err, "R10", "pulses after reset", {cmd_done, xfer_err}, 0);
      check(bus_addr == 0, "R10", "address after reset", bus_addr, 0);
   endtask

   task automatic t_cmd_basic();
      int ex;
      logic [DATA_W-1:0] exp_v;
      clear_mon();
      exp_v = mem[3];
      pulse_start(3, 13);
      wait_end(ex);
      check(ex + 1 == 7, "R2", "job latency", ex + 1, 7);
      @(negedge clk);
      check(mem[13] == exp_v, "R1", "destination value", mem[13], exp_v);
      check(rd_cyc == 1 && wr_cyc == 1, "R1", "one read one write", rd_cyc * 16 + wr_cyc, 17);
      check(done_cnt == 1, "R7", "done pulse width", done_cnt, 1);
      check(first_rd == 3, "R2", "read address", first_rd, 3);
   endtask

   task automatic t_rdy_late();
      int ex;
      clear_mon();
      rdy_en[0] = 1'b0;
      pulse_start(5, 9);
      repeat (3) @(negedge clk);
      check(rd_cyc == 0, "R3", "no read before ready", rd_cyc, 0);
      rdy_en[0] = 1'b1;
      wait_end(ex);
      @(negedge clk);
      check(viol_rd == 0 && rd_cyc == 1, "R3", "read gated by ready", viol_rd, 0);
      check(mem[9] == mem[5], "R3", "late-ready value", mem[9], mem[5]);
   endtask

   task automatic t_busy();
      int ex;
      clear_mon();
      busy_force[2] = 1'b1;
      pulse_start(4, 20);
      repeat (10) @(negedge clk);
      check(wr_cyc == 0, "R5", "write held by busy", wr_cyc, 0);
      busy_force[2] = 1'b0;
      wait_end(ex);
      @(negedge clk);
      check(viol_wr == 0 && wr_cyc == 1, "R5", "write after busy low", wr_cyc, 1);
      check(last_wr_data == mem[4], "R6", "write data is source word", last_wr_data, mem[4]);
      check(mem[20] == mem[4], "R6", "destination after hold", mem[20], mem[4]);
   endtask

   task automatic t_request();
      int ex;
      clear_mon();
      @(negedge clk);
      rd_int[1] = 1'b1;
      wait_end(ex);
      rd_int = '0;
      @(negedge clk);
      check(first_rd == 8, "R4", "route source module 1", first_rd, 8);
      check(mem[17] == mem[8], "R4", "route destination module 1", mem[17], mem[8]);
   endtask

   task automatic t_priority();
      int ex;
      clear_mon();
      @(negedge clk);
      rd_int = 4'b1110;
      wait_end(ex);
      check(first_rd == 8, "R4", "lowest request first", first_rd, 8);
      rd_int = 4'b1100;
      clear_mon();
      @(negedge clk);
      wait_end(ex);
      rd_int = '0;
      check(first_rd == 16, "R4", "next lowest request", first_rd, 16);
      @(negedge clk);
      check(mem[25] == mem[16], "R4", "route destination module 2", mem[25], mem[16]);
   endtask

   task automatic t_cmd_wins();
      int ex;
      clear_mon();
      @(negedge clk);
      rd_int[3] = 1'b1;
      cmd_src = 2; cmd_dst = 30; cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
      wait_end(ex);
      rd_int = '0;
      check(first_rd == 2, "R2", "command beats request", first_rd, 2);
      repeat (2) @(negedge clk);
   endtask

   task automatic t_ignore();
      int ex;
      logic [DATA_W-1:0] keep;
      repeat (12) @(negedge clk);
      clear_mon();
      keep = mem[31];
      pulse_start(1, 10);
      @(negedge clk);
      cmd_src = 6; cmd_dst = 31; cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
      wait_end(ex);
      repeat (12) @(negedge clk);
      check(done_cnt == 1 && rd_cyc == 1, "R9", "busy start ignored", done_cnt, 1);
      check(mem[31] == keep, "R9", "ignored destination untouched", mem[31], keep);
   endtask

   task automatic t_timeout();
      int ex;
      logic [DATA_W-1:0] keep;
      clear_mon();
      keep = mem[15];
      rdy_en = '0;
      pulse_start(7, 15);
      wait_end(ex);
      check(ex + 1 == LIMIT + 2, "R8", "timeout latency", ex + 1, LIMIT + 2);
      repeat (4) @(negedge clk);
      check(err_cnt == 1, "R8", "error pulse", err_cnt, 1);
      check(wr_cyc == 0 && done_cnt == 0, "R8", "no write or done on abort", wr_cyc + done_cnt, 0);
      check(mem[15] == keep, "R8", "destination kept", mem[15], keep);
      rdy_en = '1;
      clear_mon();
      pulse_start(7, 15);
      wait_end(ex);
      @(negedge clk);
      check(mem[15] == mem[7] && done_cnt == 1, "R8", "recovery job", mem[15], mem[7]);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_cmd_basic();
      t_rdy_late();
      t_busy();
      t_request();
      t_priority();
      t_cmd_wins();
      t_ignore();
      t_timeout();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule